// File: doc/BRIEF.md
# Debug-Mode Control Register with Deferred Imprecise Errors

This block is the debug control and status register of a small processor core. It keeps a record of why the core last entered debug mode, holds the core's debug-mode flag, and owns a mask bit, the error inhibit. While the inhibit is set, four classes of imprecise error are held back: instruction-fetch bus error, data bus error, cache error and machine check. Each class has a sticky pending bit. When the inhibit clears, the held errors are turned into exception requests, one per cycle, highest priority first.

The surrounding pipeline pulses `dbg_entry` with a set of cause flags when it takes a debug exception. It pulses `dm_exc` with a cause code when an exception occurs while already in debug mode, and pulses `dbg_ret` for the debug return. Error sources pulse their strobes. Debug-mode software reads the register through `csr_rdata` and writes it through `sw_we`/`sw_wdata`. The core takes an imprecise error whenever `take_req` shows a bit, using `take_code` as the exception code. A released error issued while the core is still in debug mode counts as an exception in debug mode. It therefore sets the inhibit again, so only one error leaves per release in that case.

Two state machines drive the behaviour. The mode machine has states MODE_RUN and MODE_DEBUG, with transitions RUN→DEBUG on entry and DEBUG→RUN on return. The release machine has states ST_IDLE (no inhibit, nothing pending), ST_HOLD (inhibit set) and ST_RELEASE (inhibit clear, something pending). Its transitions are IDLE→HOLD and RELEASE→HOLD when the inhibit is set, HOLD→RELEASE when the inhibit clears with errors pending, HOLD→IDLE when it clears with nothing pending, IDLE→RELEASE when an error arrives with the inhibit clear, and RELEASE→IDLE when the last pending bit is issued.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After reset the register reads zero, except bit 9, which reflects `cfg_no_step`. `take_req` is 0.
- R2: Register layout: bits [7:0] cause flags, bit 8 step enable, bit 9 no-step config, bits [14:10] cause code, bit 15 inhibit, bits [19:16] pending (bit 16 fetch bus, 17 data bus, 18 cache, 19 machine check), bit 20 debug mode. A `dbg_entry` pulse sets the debug-mode bit and the inhibit, and loads the cause flags from `entry_cause`, all visible one cycle later.
- R3: A `dbg_ret` pulse clears the debug-mode bit and the inhibit one cycle later.
- R4: A `dm_exc` pulse while in debug mode clears all cause flags, loads `dm_exc_code` into the cause code and sets the inhibit.
- R5: While the inhibit is set, error strobes set their pending bits, `take_req` stays 0 and no pending bit clears.
- R6: With the inhibit clear, `take_req` (one-hot: bit 0 fetch bus, 1 data bus, 2 cache, 3 machine check) shows the highest-priority pending bit in the order machine check, cache, data bus, fetch bus. That pending bit clears at the next edge, so one request is issued per cycle.
- R7: `take_code` is 24 for machine check, 30 for cache error, 7 for data bus error and 6 for fetch bus error. A request issued in debug mode re-sets the inhibit, clears the cause flags and loads its code into the cause code.
- R8: Software writes in debug mode set a pending bit where the written bit is 1, leave it unchanged where it is 0, and write the inhibit (bit 15).
- R9: An error strobe in the same cycle as the request for that error leaves the pending bit set.
- R10: With `cfg_no_step` at 1 the step enable reads 0 and writes to it are ignored. With it at 0 software sets and clears it.
- R11: Software writes while not in debug mode have no effect.
- R12: Bits [31:21] always read 0, and `take_req` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_no_step | input | 1 | 1: step enable unavailable |
| dbg_entry | input | 1 | Debug exception taken |
| entry_cause | input | 8 | Cause flags for the entry |
| dm_exc | input | 1 | Exception raised while in debug mode |
| dm_exc_code | input | 5 | Code of that exception |
| dbg_ret | input | 1 | Debug return |
| err_ifetch_bus | input | 1 | Instruction-fetch bus error event |
| err_data_bus | input | 1 | Data bus error event |
| err_cache | input | 1 | Cache error event |
| err_mcheck | input | 1 | Machine check event |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| csr_rdata | output | 32 | Register value |
| take_req | output | 4 | One-hot exception request |
| take_code | output | 5 | Exception code for the request |

## Verification
A wrong release state shows at `take_req` in the same cycle, because the request is decoded straight from registered state. A request while inhibited, two bits at once, or the wrong priority is therefore visible at the first sample after the edge that caused it. A pending bit that fails to clear, or one that clears while held, shows in bits [19:16] of `csr_rdata` one cycle after the request, and it shows again as a repeated request in that cycle. Mode, inhibit and cause errors appear in the read value at the first sample after the triggering pulse.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

    localparam int CSR_W   = 32;
    localparam int CAUSE_W = 8;
    localparam int ERR_N   = 4;
    localparam int CODE_W  = 5;

    // Field positions in the read value
    localparam int POS_CAUSE  = 0;
    localparam int POS_SST    = POS_CAUSE + CAUSE_W;
    localparam int POS_NOSTEP = POS_SST + 1;
    localparam int POS_CODE   = POS_NOSTEP + 1;
    localparam int POS_INH    = POS_CODE + CODE_W;
    localparam int POS_PEND   = POS_INH + 1;
    localparam int POS_DM     = POS_PEND + ERR_N;
    localparam int USED_W     = POS_DM + 1;

    // Error class index, ascending priority
    localparam int ERR_IFETCH = 0;
    localparam int ERR_DBUS   = 1;
    localparam int ERR_CACHE  = 2;
    localparam int ERR_MCHECK = 3;

    localparam logic [CODE_W-1:0] CODE_IBE    = 5'd6;
    localparam logic [CODE_W-1:0] CODE_DBE    = 5'd7;
    localparam logic [CODE_W-1:0] CODE_MCHECK = 5'd24;
    localparam logic [CODE_W-1:0] CODE_CACHE  = 5'd30;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RELEASE
    } defer_state_e;

    typedef enum logic {
        MODE_RUN,
        MODE_DEBUG
    } mode_state_e;

    // Highest index wins
    function automatic logic [ERR_N-1:0] pick_highest(input logic [ERR_N-1:0] v);
        logic [ERR_N-1:0] r;
        r = '0;
        for (int i = 0; i < ERR_N; i++) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] err_code(input logic [ERR_N-1:0] oh);
        logic [CODE_W-1:0] c;
        c = '0;
        if (oh[ERR_IFETCH]) c = CODE_IBE;
        if (oh[ERR_DBUS])   c = CODE_DBE;
        if (oh[ERR_CACHE])  c = CODE_CACHE;
        if (oh[ERR_MCHECK]) c = CODE_MCHECK;
        return c;
    endfunction

endpackage

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic entry_i,
    input  logic dret_i,
    input  logic exc_i,
    input  logic sw_we_i,
    input  logic sw_inh_i,
    input  logic sw_sst_i,
    input  logic cfg_no_step_i,
    output logic dm_o,
    output logic inh_o,
    output logic inh_nxt_o,
    output logic sst_o
);
    import dbg_ctl_pkg::*;

    mode_state_e mode_q, mode_d;
    logic        inh_q;
    logic        sst_q, sst_d;

    // Mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (entry_i) mode_d = MODE_DEBUG;
            end
            MODE_DEBUG: begin
                if (dret_i && !entry_i) mode_d = MODE_RUN;
            end
        endcase
    end

    // Inhibit: setting events override the return, which overrides software
    always_comb begin
        inh_nxt_o = inh_q;
        if (sw_we_i)           inh_nxt_o = sw_inh_i;
        if (dret_i)            inh_nxt_o = 1'b0;
        if (entry_i || exc_i)  inh_nxt_o = 1'b1;
    end

    always_comb begin
        sst_d = sst_q;
        if (sw_we_i && !cfg_no_step_i) sst_d = sw_sst_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q <= 1'b0;
            sst_q <= 1'b0;
        end else begin
            inh_q <= inh_nxt_o;
            sst_q <= sst_d;
        end
    end

    always_comb begin
        dm_o  = (mode_q == MODE_DEBUG);
        inh_o = inh_q;
        sst_o = sst_q && !cfg_no_step_i;
    end

    // R2
    entry_sets_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_i |=> (dm_o && inh_o));

    // R3
    dret_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dret_i && !entry_i && !exc_i) |=> (!dm_o && !inh_o));

    // R10
    nostep_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_no_step_i |=> $stable(sst_q));

endmodule

// File: rtl/dbg_cause_track.sv
module dbg_cause_track #(
    parameter int N_CAUSE = dbg_ctl_pkg::CAUSE_W,
    parameter int C_W     = dbg_ctl_pkg::CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               entry_i,
    input  logic [N_CAUSE-1:0] cause_i,
    input  logic               exc_i,
    input  logic [C_W-1:0]     exc_code_i,
    output logic [N_CAUSE-1:0] cause_o,
    output logic [C_W-1:0]     code_o
);
    logic [N_CAUSE-1:0] cause_q, cause_d;
    logic [C_W-1:0]     code_q, code_d;

    always_comb begin
        cause_d = cause_q;
        code_d  = code_q;
        if (entry_i) cause_d = cause_i;
        if (exc_i) begin
            cause_d = '0;
            code_d  = exc_code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            code_q  <= '0;
        end else begin
            cause_q <= cause_d;
            code_q  <= code_d;
        end
    end

    assign cause_o = cause_q;
    assign code_o  = code_q;

    // R4
    exc_clears_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (cause_o == '0));

    // R4
    exc_loads_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (code_o == $past(exc_code_i)));

endmodule

// File: rtl/dbg_err_defer.sv
module dbg_err_defer #(
    parameter int N_ERR = dbg_ctl_pkg::ERR_N,
    parameter int C_W   = dbg_ctl_pkg::CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] ev_i,
    input  logic [N_ERR-1:0] sw_set_i,
    input  logic             inh_q_i,
    input  logic             inh_nxt_i,
    output logic [N_ERR-1:0] pend_o,
    output logic [N_ERR-1:0] take_o,
    output logic [C_W-1:0]   take_code_o
);
    import dbg_ctl_pkg::*;

    defer_state_e     state_q, state_d;
    logic [N_ERR-1:0] pend_q, pend_d, set_v;

    assign set_v = ev_i | sw_set_i;

    // Setting beats the clear caused by a request
    always_comb begin
        pend_d = (pend_q & ~take_o) | set_v;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (inh_nxt_i)   state_d = ST_HOLD;
                else if (|pend_d) state_d = ST_RELEASE;
            end
            ST_HOLD: begin
                if (!inh_nxt_i) state_d = (|pend_d) ? ST_RELEASE : ST_IDLE;
            end
            ST_RELEASE: begin
                if (inh_nxt_i)    state_d = ST_HOLD;
                else if (!(|pend_d)) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // Outputs
    always_comb begin
        take_o = '0;
        unique case (state_q)
            ST_IDLE:    take_o = '0;
            ST_HOLD:    take_o = '0;
            ST_RELEASE: take_o = pick_highest(pend_q);
            default:    take_o = '0;
        endcase
        take_code_o = err_code(take_o);
        pend_o      = pend_q;
    end

    // R12
    take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_o));

    // R5
    hold_matches_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) == inh_q_i);

    // R5
    held_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inh_q_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R6
    taken_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(take_o & ~set_v)) |=> ((pend_q & $past(take_o & ~set_v)) == '0));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(take_o & set_v)) |=> ((pend_q & $past(take_o & set_v)) == $past(take_o & set_v)));

endmodule

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_no_step,
    input  logic        dbg_entry,
    input  logic [7:0]  entry_cause,
    input  logic        dm_exc,
    input  logic [4:0]  dm_exc_code,
    input  logic        dbg_ret,
    input  logic        err_ifetch_bus,
    input  logic        err_data_bus,
    input  logic        err_cache,
    input  logic        err_mcheck,
    input  logic        sw_we,
    input  logic [31:0] sw_wdata,
    output logic [31:0] csr_rdata,
    output logic [3:0]  take_req,
    output logic [4:0]  take_code
);
    import dbg_ctl_pkg::*;

    logic              dm, inh, inh_nxt, sst;
    logic              sw_we_dm, take_in_dm, exc_all;
    logic [CODE_W-1:0] exc_code_all, cause_code;
    logic [CAUSE_W-1:0] cause_flags;
    logic [ERR_N-1:0]  ev_vec, sw_set, pend, take;
    logic [CSR_W-1:0]  unused_wbits;

    assign unused_wbits = sw_wdata;

    always_comb begin
        ev_vec             = '0;
        ev_vec[ERR_IFETCH] = err_ifetch_bus;
        ev_vec[ERR_DBUS]   = err_data_bus;
        ev_vec[ERR_CACHE]  = err_cache;
        ev_vec[ERR_MCHECK] = err_mcheck;
    end

    assign sw_we_dm     = sw_we && dm;
    assign sw_set       = sw_we_dm ? sw_wdata[POS_PEND +: ERR_N] : '0;
    assign take_in_dm   = dm && (|take);
    assign exc_all      = (dm_exc && dm) || take_in_dm;
    assign exc_code_all = take_in_dm ? take_code : dm_exc_code;

    dbg_mode_ctl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .entry_i       (dbg_entry),
        .dret_i        (dbg_ret),
        .exc_i         (exc_all),
        .sw_we_i       (sw_we_dm),
        .sw_inh_i      (sw_wdata[POS_INH]),
        .sw_sst_i      (sw_wdata[POS_SST]),
        .cfg_no_step_i (cfg_no_step),
        .dm_o          (dm),
        .inh_o         (inh),
        .inh_nxt_o     (inh_nxt),
        .sst_o         (sst)
    );

    dbg_cause_track #(
        .N_CAUSE (CAUSE_W),
        .C_W     (CODE_W)
    ) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .entry_i    (dbg_entry),
        .cause_i    (entry_cause),
        .exc_i      (exc_all),
        .exc_code_i (exc_code_all),
        .cause_o    (cause_flags),
        .code_o     (cause_code)
    );

    dbg_err_defer #(
        .N_ERR (ERR_N),
        .C_W   (CODE_W)
    ) u_defer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_i        (ev_vec),
        .sw_set_i    (sw_set),
        .inh_q_i     (inh),
        .inh_nxt_i   (inh_nxt),
        .pend_o      (pend),
        .take_o      (take),
        .take_code_o (take_code)
    );

    assign take_req = take;

    always_comb begin
        csr_rdata                       = '0;
        csr_rdata[POS_CAUSE +: CAUSE_W] = cause_flags;
        csr_rdata[POS_SST]              = sst;
        csr_rdata[POS_NOSTEP]           = cfg_no_step;
        csr_rdata[POS_CODE +: CODE_W]   = cause_code;
        csr_rdata[POS_INH]              = inh;
        csr_rdata[POS_PEND +: ERR_N]    = pend;
        csr_rdata[POS_DM]               = dm;
    end

    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[CSR_W-1:USED_W] == '0);

    // R7
    dm_take_reinhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_in_dm |=> csr_rdata[POS_INH]);

endmodule

// File: tb/dbg_ctl_reg_tb_top.sv
module dbg_ctl_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_no_step;
    logic        dbg_entry;
    logic [7:0]  entry_cause;
    logic        dm_exc;
    logic [4:0]  dm_exc_code;
    logic        dbg_ret;
    logic        err_ifetch_bus, err_data_bus, err_cache, err_mcheck;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic [31:0] csr_rdata;
    logic [3:0]  take_req;
    logic [4:0]  take_code;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    dbg_ctl_reg dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_no_step    (cfg_no_step),
        .dbg_entry      (dbg_entry),
        .entry_cause    (entry_cause),
        .dm_exc         (dm_exc),
        .dm_exc_code    (dm_exc_code),
        .dbg_ret        (dbg_ret),
        .err_ifetch_bus (err_ifetch_bus),
        .err_data_bus   (err_data_bus),
        .err_cache      (err_cache),
        .err_mcheck     (err_mcheck),
        .sw_we          (sw_we),
        .sw_wdata       (sw_wdata),
        .csr_rdata      (csr_rdata),
        .take_req       (take_req),
        .take_code      (take_code)
    );

    localparam logic [2:0] OP_IDLE  = 3'd0;
    localparam logic [2:0] OP_ENTRY = 3'd1;
    localparam logic [2:0] OP_DRET  = 3'd2;
    localparam logic [2:0] OP_WRITE = 3'd3;
    localparam logic [2:0] OP_ERR   = 3'd4;
    localparam logic [2:0] OP_DMEXC = 3'd5;

    // {req, op, data, expected csr, expected take}
    localparam int NV = 18;
    localparam logic [74:0] VEC [NV] = '{
        {4'd1,  OP_IDLE,  32'h0,        32'h00000000, 4'h0}, // R1 reset state
        {4'd2,  OP_ENTRY, 32'h12,       32'h00108012, 4'h0}, // R2 entry
        {4'd5,  OP_ERR,   32'h1,        32'h00118012, 4'h0}, // R5 held
        {4'd5,  OP_ERR,   32'hC,        32'h001D8012, 4'h0}, // R5 two more held
        {4'd8,  OP_WRITE, 32'h00008100, 32'h001D8112, 4'h0}, // R8 zero leaves pending
        {4'd8,  OP_WRITE, 32'h00020100, 32'h001F0112, 4'h8}, // R8 set by write, release
        {4'd7,  OP_IDLE,  32'h0,        32'h0017E100, 4'h0}, // R7 re-inhibit, code 24
        {4'd3,  OP_DRET,  32'h0,        32'h00076100, 4'h4}, // R3 return, cache next
        {4'd6,  OP_IDLE,  32'h0,        32'h00036100, 4'h2}, // R6 data bus
        {4'd6,  OP_IDLE,  32'h0,        32'h00016100, 4'h1}, // R6 fetch bus
        {4'd6,  OP_IDLE,  32'h0,        32'h00006100, 4'h0}, // R6 drained
        {4'd11, OP_WRITE, 32'h000F8000, 32'h00006100, 4'h0}, // R11 write ignored
        {4'd6,  OP_ERR,   32'h2,        32'h00026100, 4'h2}, // R6 immediate take
        {4'd6,  OP_IDLE,  32'h0,        32'h00006100, 4'h0}, // R6 cleared
        {4'd2,  OP_ENTRY, 32'h81,       32'h0010E181, 4'h0}, // R2 second entry
        {4'd4,  OP_DMEXC, 32'hD,        32'h0010B500, 4'h0}, // R4 exception in mode
        {4'd10, OP_WRITE, 32'h0,        32'h00103400, 4'h0}, // R10 step enable cleared
        {4'd3,  OP_DRET,  32'h0,        32'h00003400, 4'h0}  // R3 return
    };

    task automatic clear_inputs();
        dbg_entry      = 1'b0;
        entry_cause    = '0;
        dm_exc         = 1'b0;
        dm_exc_code    = '0;
        dbg_ret        = 1'b0;
        err_ifetch_bus = 1'b0;
        err_data_bus   = 1'b0;
        err_cache      = 1'b0;
        err_mcheck     = 1'b0;
        sw_we          = 1'b0;
        sw_wdata       = '0;
    endtask

    // Drive at a falling edge, hold over one rising edge, return at the next falling edge
    task automatic apply(input logic [2:0] op, input logic [31:0] d);
        case (op)
            OP_ENTRY: begin dbg_entry = 1'b1; entry_cause = d[7:0]; end
            OP_DRET:  dbg_ret = 1'b1;
            OP_WRITE: begin sw_we = 1'b1; sw_wdata = d; end
            OP_ERR: begin
                err_ifetch_bus = d[0];
                err_data_bus   = d[1];
                err_cache      = d[2];
                err_mcheck     = d[3];
            end
            OP_DMEXC: begin dm_exc = 1'b1; dm_exc_code = d[4:0]; end
            default: ;
        endcase
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        rst_n       = 1'b0;
        cfg_no_step = 1'b0;
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][70:68], VEC[i][67:36]);
            check(int'(VEC[i][74:71]), "table csr", csr_rdata, VEC[i][35:4]);
            check(int'(VEC[i][74:71]), "table take", {28'h0, take_req}, {28'h0, VEC[i][3:0]});
        end

        // R9: event repeated in the cycle of its own request
        apply(OP_ERR, 32'h1);
        check(9, "first event csr", csr_rdata, 32'h00013400);
        apply(OP_ERR, 32'h1);
        check(9, "set wins csr", csr_rdata, 32'h00013400);
        check(9, "set wins take", {28'h0, take_req}, 32'h1);
        apply(OP_IDLE, 32'h0);
        check(9, "drained csr", csr_rdata, 32'h00003400);

        // R10: no-step configuration
        cfg_no_step = 1'b1;
        #1;
        check(10, "config bit", csr_rdata, 32'h00003600);
        apply(OP_ENTRY, 32'h0);
        apply(OP_WRITE, 32'h00008100);
        check(10, "step write ignored", csr_rdata, 32'h0010B600);
        cfg_no_step = 1'b0;
        #1;
        check(10, "step still clear", csr_rdata, 32'h0010B400);
        apply(OP_WRITE, 32'h00008100);
        check(10, "step write taken", csr_rdata, 32'h0010B500);

        // R12: all-ones write leaves reserved bits zero
        apply(OP_WRITE, 32'hFFFFFFFF);
        check(12, "reserved zero", csr_rdata, 32'h001FB500);
        check(12, "no take held", {28'h0, take_req}, 32'h0);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "reset csr", csr_rdata, 32'h00000000);
        check(1, "reset take", {28'h0, take_req}, 32'h0);
        rst_n = 1'b1;

        // R7: cache error released in debug mode
        apply(OP_ENTRY, 32'h0);
        apply(OP_ERR, 32'h4);
        check(5, "cache held", csr_rdata, 32'h00148000);
        apply(OP_WRITE, 32'h0);
        check(7, "cache take", {28'h0, take_req}, 32'h4);
        check(7, "cache code", {27'h0, take_code}, 32'd30);
        apply(OP_IDLE, 32'h0);
        check(7, "cache recorded", csr_rdata, 32'h0010F800);
        check(7, "single release", {28'h0, take_req}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule